// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block runs a single-rank SDRAM with four banks, 2048 rows, 256 columns and a 32-bit data bus. Its clock is 100 MHz, and every timing constant is a whole number of clock cycles. After reset it waits for a programmable settling time. It then closes every bank, issues two refresh cycles and writes the mode register. From that point it serves one user access at a time.

Each user access is a single word, read or written, and every access closes its row automatically. A user presents an address, a direction and write data. A transfer happens on the cycle where `req_valid` and `req_ready` are both high. The controller then opens the row, issues the column command with the auto-close flag set, and holds `req_ready` low until the row cycle time has passed. A free-running interval timer raises a refresh request. That request is served before any waiting user access.

The sequencer has eight states:

- **BOOT**: counts out the settling time.
- **PALL**: closes all banks.
- **REF**: issues a refresh.
- **MRS**: writes the mode register.
- **IDLE**: accepts a request, or starts a pending refresh.
- **ACT**: opens the row.
- **COL**: issues the read or write.
- **WAIT**: counts out the spacing before the next command state.

The transitions are:

- BOOT to PALL.
- PALL to WAIT, then REF.
- Boot REF to WAIT, then a second REF.
- Second boot REF to WAIT, then MRS.
- MRS to WAIT, then IDLE.
- IDLE to ACT on an accepted request.
- IDLE to REF when a refresh is pending.
- ACT to WAIT, then COL.
- COL to WAIT, then IDLE.
- Run-time REF to WAIT, then IDLE.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, and during the first INIT_CYCLES cycles after reset is released:
  - the command is NOP;
  - `req_ready`, `rd_valid` and `sd_dq_oe` are low.

  `req_ready` stays low until the mode register has been written.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode register set 0000. The boot order is:
  1. precharge with A10 = 1 (all banks);
  2. refresh;
  3. refresh;
  4. mode register set with address 0x020, meaning A2:0 = 000 (burst of one), A3 = 0 (sequential) and A6:4 = 010 (latency 2).
- R3: Boot spacing is measured between command cycles:
  - from the precharge to the first refresh: at least T_RP;
  - from each refresh to the next command: at least T_RFC;
  - from the mode register set to the first activate: at least T_MRD.
- R4: A request address {bank[20:19], row[18:8], col[7:0]} leads to the following commands:
  - An activate carries the bank on `sd_ba` and the row on `sd_addr`.
  - The column command comes exactly T_RCD cycles after the activate, to the same bank.
  - On the column command, `sd_addr` carries the column on A7:0, A10 = 1 and every other bit 0.
  - An activate is followed by a NOP.
- R5: `sd_dq_oe` is high only in the cycle of a write command. In that cycle `sd_dq_out` equals the accepted write data.
- R6: For each read command issued in cycle c, `rd_valid` is high in cycle c+3 only. `rd_data` equals the `sd_dq_in` value sampled at the clock edge that ends cycle c+2.
- R7: The cycle gap from an activate or refresh to the next activate or refresh is at least T_RC. This also covers write recovery, because T_RC is at least T_RCD+T_WR+T_RP.
- R8: An accepted request produces an activate in the next cycle. After an activate, `req_ready` stays low for the next T_RC-2 cycles.
- R9: A refresh is requested every REF_INTERVAL cycles after boot. A pending refresh is issued before a waiting user request is accepted. Consecutive run-time refreshes are never more than REF_INTERVAL+T_RC+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | {bank, row, column} |
| req_wdata | input | 32 | Write word |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | `rd_data` is valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 11 | Row / column / mode address |
| sd_dq_out | output | 32 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 32 | Data returned by the memory |

## Verification
The bench builds the controller with INIT_CYCLES = 30 and REF_INTERVAL = 80. All timing constants keep their 100 MHz defaults. The short settling time reaches the full boot order within a few dozen cycles. The short refresh interval produces several run-time refreshes during a stream of back-to-back accesses. That stream keeps a user request waiting whenever a refresh comes due, so refresh priority and the refresh gap bound are both exercised. Addresses at the corners of bank, row and column reach every field of the address mapping.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_BOOT, ST_PALL, ST_REF, ST_MRS, ST_IDLE, ST_ACT, ST_COL, ST_WAIT
    } seq_state_e;

    localparam int          CAS_LAT   = 2;
    localparam int          AP_BIT    = 10;
    // burst 1, sequential, latency 2
    localparam logic [10:0] MODE_WORD = 11'h020;

    function automatic int at_least2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            if (!run || tick) cnt <= '0;
            else              cnt <= cnt + 1'b1;
            pending <= (pending && !ack) || tick;
        end
    end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    logic [LAT-1:0] flag;

    generate
        if (LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) flag <= '0;
                else        flag <= issue;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) flag <= '0;
                else        flag <= {flag[LAT-2:0], issue};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= flag[LAT-1];
            if (flag[LAT-1]) data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 11,
    parameter int COL_W        = 8,
    parameter int INIT_CYCLES  = 20000,
    parameter int REF_INTERVAL = 1560,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 5,
    parameter int T_RC         = 7,
    parameter int T_RFC        = 7,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_valid,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_addr,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;

    // full row cycle from activate to the next activate, per direction
    localparam int RD_A   = (T_RAS + T_RP > T_RCD + 1 + T_RP) ? T_RAS + T_RP : T_RCD + 1 + T_RP;
    localparam int REC_RD = (T_RC > RD_A) ? T_RC : RD_A;
    localparam int WR_A   = T_RCD + T_WR + T_RP;
    localparam int REC_WR = (T_RC > WR_A) ? T_RC : WR_A;

    localparam int CNT_W  = $clog2(INIT_CYCLES + REC_RD + REC_WR + T_RFC + T_MRD + 8);

    // WAIT load values: the next command state starts N cycles after the issuing one
    localparam logic [CNT_W-1:0] W_RCD  = CNT_W'(at_least2(T_RCD) - 1);
    localparam logic [CNT_W-1:0] W_RP   = CNT_W'(at_least2(T_RP) - 1);
    localparam logic [CNT_W-1:0] W_RFCB = CNT_W'(at_least2(T_RFC) - 1);
    localparam logic [CNT_W-1:0] W_RFCR = CNT_W'(at_least2(T_RFC - 1) - 1);
    localparam logic [CNT_W-1:0] W_MRD  = CNT_W'(at_least2(T_MRD - 1) - 1);
    localparam logic [CNT_W-1:0] W_RD   = CNT_W'(at_least2(REC_RD - T_RCD - 1) - 1);
    localparam logic [CNT_W-1:0] W_WR   = CNT_W'(at_least2(REC_WR - T_RCD - 1) - 1);

    seq_state_e        state, ret_state;
    logic [CNT_W-1:0]  wcnt;
    logic              booted, boot_ref1;
    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_wr;
    logic [DATA_W-1:0] lat_data;
    logic              ref_pending;
    cmd_e              cmd;

    assign req_ready = (state == ST_IDLE) && !ref_pending;

    // state register and sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_BOOT;
            ret_state <= ST_IDLE;
            wcnt      <= CNT_W'(INIT_CYCLES);
            booted    <= 1'b0;
            boot_ref1 <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wr    <= 1'b0;
            lat_data  <= '0;
        end else begin
            unique case (state)
                ST_BOOT: begin
                    if (wcnt == '0) state <= ST_PALL;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_PALL: begin
                    wcnt <= W_RP; ret_state <= ST_REF; state <= ST_WAIT;
                end
                ST_REF: begin
                    state <= ST_WAIT;
                    if (booted) begin
                        wcnt <= W_RFCR; ret_state <= ST_IDLE;
                    end else if (!boot_ref1) begin
                        boot_ref1 <= 1'b1; wcnt <= W_RFCB; ret_state <= ST_REF;
                    end else begin
                        wcnt <= W_RFCB; ret_state <= ST_MRS;
                    end
                end
                ST_MRS: begin
                    booted <= 1'b1;
                    wcnt <= W_MRD; ret_state <= ST_IDLE; state <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        state <= ST_REF;
                    end else if (req_valid) begin
                        lat_bank <= req_addr[ADDR_W-1 -: BANK_W];
                        lat_row  <= req_addr[COL_W +: ROW_W];
                        lat_col  <= req_addr[COL_W-1:0];
                        lat_wr   <= req_write;
                        lat_data <= req_wdata;
                        state    <= ST_ACT;
                    end
                end
                ST_ACT: begin
                    wcnt <= W_RCD; ret_state <= ST_COL; state <= ST_WAIT;
                end
                ST_COL: begin
                    wcnt <= lat_wr ? W_WR : W_RD; ret_state <= ST_IDLE; state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wcnt <= CNT_W'(1)) state <= ret_state;
                    else                   wcnt  <= wcnt - 1'b1;
                end
                default: state <= ST_BOOT;
            endcase
        end
    end

    // device-side outputs decoded from state
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = '0;
        sd_addr  = '0;
        sd_dq_oe = 1'b0;
        unique case (state)
            ST_PALL: begin
                cmd = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = ROW_W'(MODE_WORD);
            end
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = lat_bank;
                sd_addr = lat_row;
            end
            ST_COL: begin
                cmd      = lat_wr ? CMD_WR : CMD_RD;
                sd_ba    = lat_bank;
                sd_addr  = ROW_W'(lat_col);
                sd_addr[AP_BIT] = 1'b1;
                sd_dq_oe = lat_wr;
            end
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_out = lat_data;

    sdram_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_ref_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (booted),
        .ack     ((state == ST_REF) && booted),
        .pending (ref_pending)
    );

    sdram_read_pipe #(
        .DATA_W (DATA_W),
        .LAT    (CAS_LAT)
    ) u_rd_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .issue ((state == ST_COL) && !lat_wr),
        .dq_in (sd_dq_in),
        .data  (rd_data),
        .valid (rd_valid)
    );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int T_RC  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dq_oe,
    input logic             rd_valid
);
    logic [3:0] cmd;
    logic [7:0] gap;
    logic       seen_row, seen_mrs;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= '0;
            seen_row <= 1'b0;
            seen_mrs <= 1'b0;
        end else begin
            if (cmd == CMD_MRS) seen_mrs <= 1'b1;
            if (cmd == CMD_ACT || cmd == CMD_REF) begin
                gap      <= 8'd1;
                seen_row <= 1'b1;
            end else if (gap != 8'hFF) begin
                gap <= gap + 1'b1;
            end
        end
    end

    a_r1_ready_after_boot: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> seen_mrs);

    a_r4_act_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> (cmd == CMD_NOP));

    a_r4_col_autoclose: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> sd_addr[AP_BIT]);

    a_r5_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (cmd == CMD_WR));

    a_r6_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cmd, 3) == CMD_RD));

    a_r7_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_row && (cmd == CMD_ACT || cmd == CMD_REF)) |-> (gap >= 8'(T_RC)));

    a_r8_accept_to_act: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(
    .ROW_W (ROW_W),
    .T_RC  (T_RC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_dq_oe  (sd_dq_oe),
    .rd_valid  (rd_valid)
);

// File: tb/sdram_seq_ctrl_tb_top.sv
module sdram_seq_ctrl_tb_top;
    import sdram_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int INIT       = 30;
    localparam int REFI       = 80;
    localparam int T_RCD      = 2;
    localparam int T_RP       = 2;
    localparam int T_RC       = 7;
    localparam int T_RFC      = 7;
    localparam int T_MRD      = 2;
    localparam int LIMIT      = 20000;

    logic        clk, rst_n;
    logic        req_valid, req_ready, req_write;
    logic [20:0] req_addr;
    logic [31:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
    logic        rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [10:0] sd_addr;

    sdram_seq_ctrl #(
        .INIT_CYCLES  (INIT),
        .REF_INTERVAL (REFI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        bit          wr;
        logic [20:0] a;
        logic [31:0] d;
        int          hs;
    } req_t;

    req_t        req_q[$];
    logic [31:0] exp_q[$];
    int          rdc_q[$];
    logic [31:0] dev_mem [logic [20:0]];
    logic [31:0] shadow  [logic [20:0]];
    logic [10:0] open_row [4];

    function automatic logic [31:0] fill(input logic [20:0] a);
        return {11'h5A5, a};
    endfunction

    // device model and monitor, all at the falling edge
    logic [31:0] s1, s2;
    bit   booted = 0;
    int   boot_idx = 0, last_boot = 0, mrs_cyc = 0;
    int   last_row = -1000, act_cyc = -1000, last_ref = -1, ref_cnt = 0;
    req_t cur;

    always @(negedge clk) begin
        logic [3:0]  c;
        logic [20:0] k;
        int          rc;
        logic [31:0] ed;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        sd_dq_in = s2;
        s2 = s1;
        if (rst_n) begin
            if (cyc < INIT && c != CMD_NOP)
                check(0, "R1", "command during settling time", 32'(c), 32'(CMD_NOP));
            if (!booted && req_ready)
                check(0, "R1", "ready before boot done", 1, 0);
            if (sd_dq_oe && c != CMD_WR)
                check(0, "R5", "oe outside write", 32'(c), 32'(CMD_WR));
            if (req_ready && booted && (cyc - act_cyc) < T_RC - 1)
                check(0, "R8", "ready inside row cycle", 32'(cyc - act_cyc), 32'(T_RC - 1));
            case (c)
                CMD_NOP: ;
                CMD_PRE: begin
                    check(!booted && boot_idx == 0 && sd_addr[10], "R2", "precharge-all first",
                          32'(boot_idx), 0);
                    check(cyc >= INIT, "R1", "settling time honoured", 32'(cyc), 32'(INIT));
                    boot_idx = 1;
                    last_boot = cyc;
                end
                CMD_REF: begin
                    if (!booted) begin
                        check(boot_idx == 1 || boot_idx == 2, "R2", "boot refresh order",
                              32'(boot_idx), 1);
                        check((cyc - last_boot) >= ((boot_idx == 1) ? T_RP : T_RFC), "R3",
                              "boot gap before refresh", 32'(cyc - last_boot), 32'(T_RP));
                        boot_idx++;
                        last_boot = cyc;
                    end else begin
                        ref_cnt++;
                        if (last_ref >= 0)
                            check((cyc - last_ref) <= REFI + T_RC + 2, "R9", "refresh gap",
                                  32'(cyc - last_ref), 32'(REFI + T_RC + 2));
                        last_ref = cyc;
                        check((cyc - last_row) >= T_RC, "R7", "refresh after row",
                              32'(cyc - last_row), 32'(T_RC));
                    end
                    last_row = cyc;
                end
                CMD_MRS: begin
                    check(boot_idx == 3 && sd_addr == 11'h020, "R2", "mode register write",
                          32'(sd_addr), 32'h020);
                    check((cyc - last_boot) >= T_RFC, "R3", "refresh to mode gap",
                          32'(cyc - last_boot), 32'(T_RFC));
                    booted = 1;
                    mrs_cyc = cyc;
                end
                CMD_ACT: begin
                    check((cyc - mrs_cyc) >= T_MRD, "R3", "mode to activate gap",
                          32'(cyc - mrs_cyc), 32'(T_MRD));
                    check((cyc - last_row) >= T_RC, "R7", "activate spacing",
                          32'(cyc - last_row), 32'(T_RC));
                    if (req_q.size() == 0) begin
                        check(0, "R4", "activate without request", 0, 1);
                    end else begin
                        cur = req_q.pop_front();
                        check({sd_ba, sd_addr} == cur.a[20:8], "R4", "bank/row",
                              32'({sd_ba, sd_addr}), 32'(cur.a[20:8]));
                        check(cyc == cur.hs + 1, "R8", "activate after accept",
                              32'(cyc), 32'(cur.hs + 1));
                    end
                    open_row[sd_ba] = sd_addr;
                    act_cyc = cyc;
                    last_row = cyc;
                end
                CMD_WR, CMD_RD: begin
                    check(cyc == act_cyc + T_RCD, "R4", "column delay",
                          32'(cyc - act_cyc), 32'(T_RCD));
                    check(sd_addr == {3'b100, cur.a[7:0]} && sd_ba == cur.a[20:19] &&
                          (c == CMD_WR) == cur.wr, "R4", "column address",
                          32'({sd_ba, sd_addr}), 32'({cur.a[20:19], 3'b100, cur.a[7:0]}));
                    k = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
                    if (c == CMD_WR) begin
                        check(sd_dq_oe && sd_dq_out == cur.d, "R5", "write data",
                              sd_dq_out, cur.d);
                        dev_mem[k] = sd_dq_out;
                    end else begin
                        s1 = dev_mem.exists(k) ? dev_mem[k] : fill(k);
                        rdc_q.push_back(cyc);
                    end
                end
                default: check(0, "R2", "unknown command", 32'(c), 32'(CMD_NOP));
            endcase
            if (rd_valid) begin
                if (exp_q.size() == 0 || rdc_q.size() == 0) begin
                    check(0, "R6", "unexpected read data", rd_data, 0);
                end else begin
                    ed = exp_q.pop_front();
                    rc = rdc_q.pop_front();
                    check(rd_data == ed, "R6", "read data", rd_data, ed);
                    check(cyc == rc + 3, "R6", "read return cycle", 32'(cyc - rc), 3);
                end
            end
        end
    end

    task automatic do_req(input bit wr, input logic [20:0] a, input logic [31:0] d);
        bit   done;
        req_t r;
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        done = 0;
        while (!done) begin
            @(negedge clk);
            if (req_ready) begin
                r.wr = wr; r.a = a; r.d = d; r.hs = cyc;
                req_q.push_back(r);
                if (wr) shadow[a] = d;
                else    exp_q.push_back(shadow.exists(a) ? shadow[a] : fill(a));
                done = 1;
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        check(0, "R1", "watchdog expired", 32'(cyc), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [20:0] a;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        s1 = '0; s2 = '0; sd_dq_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!req_ready && !rd_valid && !sd_dq_oe &&
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1", "reset state",
              32'({req_ready, rd_valid, sd_dq_oe}), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        check(boot_idx == 3 && booted, "R2", "boot complete", 32'(boot_idx), 3);

        // corners of bank, row and column (R4, R5, R6)
        do_req(1, {2'd0, 11'd0,    8'd0},   32'h1111_0001);
        do_req(1, {2'd3, 11'd2047, 8'd255}, 32'hFFFF_0003);
        do_req(1, {2'd1, 11'd5,    8'd128}, 32'h2222_0005);
        do_req(1, {2'd2, 11'd1024, 8'd1},   32'h3333_0007);
        do_req(0, {2'd0, 11'd0,    8'd0},   '0);
        do_req(0, {2'd3, 11'd2047, 8'd255}, '0);
        do_req(0, {2'd1, 11'd5,    8'd128}, '0);
        do_req(0, {2'd2, 11'd1024, 8'd1},   '0);
        do_req(0, {2'd2, 11'd77,   8'd9},   '0);   // never written
        do_req(1, {2'd1, 11'd5,    8'd128}, 32'hABCD_1234);
        do_req(0, {2'd1, 11'd5,    8'd128}, '0);   // overwrite seen

        // stream with refreshes falling due while requests wait (R9, R7, R8)
        for (int i = 0; i < 48; i++) begin
            a = {2'(i), 11'(i * 37), 8'(i * 13)};
            if (i % 3 == 2) do_req(0, {2'(i - 2), 11'((i - 2) * 37), 8'((i - 2) * 13)}, '0);
            else            do_req(1, a, 32'hC0DE_0000 + 32'(i));
        end

        for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(ref_cnt >= 2, "R9", "run-time refreshes issued", 32'(ref_cnt), 2);
        check(exp_q.size() == 0 && req_q.size() == 0, "R6", "all reads returned",
              32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule